// File: doc/BRIEF.md
# Multichannel DAC Code Calibration Engine

This block is the digital front end of a bank of 32 twelve-bit DAC channels. A single write port carries a channel number, a two-bit target selector and a twelve-bit word. The word lands in one of three coefficient registers of the addressed channel: the raw input code, the offset trim or the gain trim. A fourth selector value is reserved for special functions. This block only reports that such a write happened and stores nothing for it.

Each channel continuously derives a trimmed code from its three registers. The formula is ((gain + 2) * input) / 4096 + (offset - 2048), clamped to the range 0..4095. The trimmed codes are double buffered: they reach the DAC output registers only when the global load strobe is sampled high, and all channels update on the same clock edge.

The write port follows a valid/ready handshake. A write is accepted on a rising clock edge where both `wr_valid` and `wr_ready` are high. The block never applies back-pressure after reset: `wr_ready` is low only while reset is asserted and during the first cycle after it. The load strobe and the special-function flag are plain single-cycle signals.

Top module: `dac_cal_engine`

## Requirements
- R1: `wr_ready` is low during reset and high from the first cycle after reset release onward, so every write after that is accepted.
- R2: An accepted write uses the selector to pick its target. Selector 2'b11 writes the input code, 2'b10 the offset trim and 2'b01 the gain trim. Only the channel given by `wr_chan` changes.
- R3: A gain write stores data bits 11..1 and forces stored bit 0 to 0. Writing 0x7FF therefore stores 0x7FE.
- R4: After reset, every output code and every input code is 0, every gain trim is 0xFFE and every offset trim is 0x800 (zero offset).
- R5: The trimmed code is floor((gain+2)*input/4096) + offset - 2048. The product is formed at full width. Gains 0xFFE, 0xBFE, 0x7FE and 0x3FE scale by about 1, 0.75, 0.5 and 0.25.
- R6: The trimmed code saturates: results below 0 give 0 and results above 4095 give 4095.
- R7: Output codes change only on the clock edge that samples `load_i` high, and on that edge every channel takes its trimmed code. Writes alone never change the outputs.
- R8: When a write and a load fall in the same cycle, the load uses the register values held before that write.
- R9: An accepted write with selector 2'b00 pulses `sfr_hit` high for exactly the following cycle and changes no channel register. `sfr_hit` is low at all other times.
- R10: While `wr_valid` is low, no channel register changes, whatever values the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Block can accept a write |
| wr_chan | input | 5 | Channel number of the write |
| wr_sel | input | 2 | Target: 11 input, 10 offset, 01 gain, 00 special |
| wr_data | input | 12 | Write data word |
| load_i | input | 1 | Global load strobe for all output codes |
| sfr_hit | output | 1 | One-cycle pulse after a special-function write |
| dac_codes | output | 384 | Output codes; channel k occupies bits 12k+11..12k |

## Verification
Some properties are checked by assertions on every cycle:
- outputs hold steady without a load;
- `wr_ready` follows the reset release;
- `sfr_hit` pulses exactly after a special-function write;
- a gain write stores its word with bit 0 cleared;
- coefficient registers stay still while no write is accepted.

The arithmetic is shown only by the bench's directed scenarios, compared against an independent model. These scenarios cover the default coefficients, the four gain scale points, clamping at both ends, and a load that coincides with a write.

// File: rtl/dcal_pkg.sv
package dcal_pkg;
  typedef enum logic [1:0] {
    SEL_SPECIAL = 2'b00,
    SEL_GAIN    = 2'b01,
    SEL_OFFSET  = 2'b10,
    SEL_INPUT   = 2'b11
  } dcal_sel_e;
endpackage

// File: rtl/dcal_regbank.sv
module dcal_regbank
  import dcal_pkg::*;
#(
  parameter int NCH = 32,
  parameter int DW  = 12,
  localparam int AW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_chan,
  input  logic [1:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  output logic [NCH*DW-1:0] x1_flat,
  output logic [NCH*DW-1:0] gain_flat,
  output logic [NCH*DW-1:0] offs_flat,
  output logic            sfr_hit
);
  localparam logic [DW-1:0] GAIN_RST = {{(DW-1){1'b1}}, 1'b0};
  localparam logic [DW-1:0] OFFS_RST = {1'b1, {(DW-1){1'b0}}};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          sel_me;
    logic [DW-1:0] x1_q, gain_q, offs_q;

    assign sel_me = wr_en && (wr_chan == AW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        x1_q   <= '0;
        gain_q <= GAIN_RST;
        offs_q <= OFFS_RST;
      end else if (sel_me) begin
        case (dcal_sel_e'(wr_sel))
          SEL_INPUT:  x1_q   <= wr_data;
          SEL_OFFSET: offs_q <= wr_data;
          SEL_GAIN:   gain_q <= {wr_data[DW-1:1], 1'b0};
          default:    ;
        endcase
      end
    end

    assign x1_flat[i*DW +: DW]   = x1_q;
    assign gain_flat[i*DW +: DW] = gain_q;
    assign offs_flat[i*DW +: DW] = offs_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sfr_hit <= 1'b0;
    else        sfr_hit <= wr_en && (dcal_sel_e'(wr_sel) == SEL_SPECIAL);
  end
endmodule

// File: rtl/dcal_trim.sv
module dcal_trim #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] x1,
  input  logic [DW-1:0] gain,
  input  logic [DW-1:0] offs,
  output logic [DW-1:0] code
);
  localparam int MW = 2*DW + 1;
  localparam int SW = DW + 3;
  localparam logic signed [SW-1:0] HALF = SW'(2**(DW-1));
  localparam logic signed [SW-1:0] MAXV = SW'((2**DW) - 1);

  logic [DW:0]            gain_p2;
  logic [MW-1:0]          prod;
  logic [DW:0]            quot;
  logic signed [SW-1:0]   sum;

  always_comb begin
    gain_p2 = {1'b0, gain} + (DW+1)'(2);
    prod    = MW'(gain_p2) * MW'(x1);
    quot    = prod[MW-1:DW];
    sum     = $signed({2'b00, quot}) + $signed({3'b000, offs}) - HALF;
    if (sum < 0)         code = '0;
    else if (sum > MAXV) code = '1;
    else                 code = sum[DW-1:0];
  end
endmodule

// File: rtl/dcal_dacbank.sv
module dcal_dacbank #(
  parameter int NCH = 32,
  parameter int DW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NCH*DW-1:0] next_flat,
  output logic [NCH*DW-1:0] dac_flat
);
  always_ff @(posedge clk) begin
    if (!rst_n)    dac_flat <= '0;
    else if (load) dac_flat <= next_flat;
  end
endmodule

// File: rtl/dac_cal_engine.sv
module dac_cal_engine #(
  parameter int NCH = 32,
  parameter int DW  = 12,
  localparam int AW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW-1:0]     wr_chan,
  input  logic [1:0]        wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic              load_i,
  output logic              sfr_hit,
  output logic [NCH*DW-1:0] dac_codes
);
  logic              ready_q;
  logic              wr_en;
  logic [NCH*DW-1:0] x1_flat, gain_flat, offs_flat, trim_flat;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign wr_ready = ready_q;
  assign wr_en    = wr_valid && ready_q;

  dcal_regbank #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_sel(wr_sel), .wr_data(wr_data), .x1_flat(x1_flat),
    .gain_flat(gain_flat), .offs_flat(offs_flat), .sfr_hit(sfr_hit)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_trim
    dcal_trim #(.DW(DW)) u_trim (
      .x1(x1_flat[i*DW +: DW]), .gain(gain_flat[i*DW +: DW]),
      .offs(offs_flat[i*DW +: DW]), .code(trim_flat[i*DW +: DW])
    );
  end

  dcal_dacbank #(.NCH(NCH), .DW(DW)) u_dac (
    .clk(clk), .rst_n(rst_n), .load(load_i),
    .next_flat(trim_flat), .dac_flat(dac_codes)
  );
endmodule

// File: rtl/dcal_chk.sv
module dcal_chk #(
  parameter int NCH = 32,
  parameter int DW  = 12,
  localparam int AW = $clog2(NCH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [AW-1:0]     wr_chan,
  input logic [1:0]        wr_sel,
  input logic [DW-1:0]     wr_data,
  input logic              load_i,
  input logic              sfr_hit,
  input logic [NCH*DW-1:0] dac_codes,
  input logic [NCH*DW-1:0] x1_flat,
  input logic [NCH*DW-1:0] gain_flat,
  input logic [NCH*DW-1:0] offs_flat
);
  logic acc;
  assign acc = wr_valid && wr_ready;

  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> wr_ready);

  // R7
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(dac_codes));

  // R9
  sfr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_sel == 2'b00) |=> sfr_hit);

  // R9
  sfr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && wr_sel == 2'b00) |=> !sfr_hit);

  // R3
  gain_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_sel == 2'b01) |=>
      gain_flat[$past(wr_chan)*DW +: DW] == {$past(wr_data[DW-1:1]), 1'b0});

  // R10
  idle_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(x1_flat) && $stable(gain_flat) && $stable(offs_flat)));
endmodule

bind dac_cal_engine dcal_chk #(.NCH(NCH), .DW(DW)) u_dcal_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_chan(wr_chan), .wr_sel(wr_sel), .wr_data(wr_data), .load_i(load_i),
  .sfr_hit(sfr_hit), .dac_codes(dac_codes), .x1_flat(x1_flat),
  .gain_flat(gain_flat), .offs_flat(offs_flat)
);

// File: tb/dac_cal_engine_bench.sv
module dac_cal_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;
  localparam int DW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [4:0] wr_chan = '0;
  logic [1:0] wr_sel = '0;
  logic [11:0] wr_data = '0;
  logic load_i = 1'b0;
  logic sfr_hit;
  logic [NCH*DW-1:0] dac_codes;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_x1 [NCH];
  int m_g  [NCH];
  int m_c  [NCH];
  int m_dac[NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_cal_engine u_dac_cal_engine (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_sel(wr_sel), .wr_data(wr_data), .load_i(load_i),
    .sfr_hit(sfr_hit), .dac_codes(dac_codes)
  );

  function automatic int ref_code(int x1, int g, int c);
    int v;
    v = ((g + 2) * x1) / 4096 + c - 2048;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    int bad = 0;
    checks++;
    for (int k = 0; k < NCH; k++) begin
      if (int'(dac_codes[k*DW +: DW]) != m_dac[k]) begin
        bad++;
        $display("FAIL %s ch=%0d actual=%0d expected=%0d", tag, k,
                 dac_codes[k*DW +: DW], m_dac[k]);
      end
    end
    if (bad != 0) failures++;
  endtask

  task automatic model_write(int ch, int sel, int d);
    case (sel)
      3: m_x1[ch] = d;
      2: m_c[ch]  = d;
      1: m_g[ch]  = d & 12'hFFE;
      default: ;
    endcase
  endtask

  task automatic model_load();
    for (int k = 0; k < NCH; k++) m_dac[k] = ref_code(m_x1[k], m_g[k], m_c[k]);
  endtask

  task automatic do_write(int ch, int sel, int d);
    @(negedge clk);
    wr_valid = 1'b1; wr_chan = 5'(ch); wr_sel = 2'(sel); wr_data = 12'(d);
    @(negedge clk);
    wr_valid = 1'b0;
    model_write(ch, sel, d);
  endtask

  task automatic do_load();
    @(negedge clk);
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    model_load();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", int'(wr_ready), 0);
    rst_n = 1'b1;
    for (int k = 0; k < NCH; k++) begin
      m_x1[k] = 0; m_g[k] = 12'hFFE; m_c[k] = 12'h800; m_dac[k] = 0;
    end
    @(negedge clk);
    chk("R1 ready after reset", int'(wr_ready), 1);
    chk_all("R4 outputs zero after reset");
    do_load();
    chk_all("R4 zero input codes after reset");
    do_write(3, 3, 12'hFFF);
    do_load();
    chk("R4 default gain/offset pass full scale", int'(dac_codes[3*DW +: DW]), 4095);
  endtask

  task automatic t_decode();
    do_write(5, 3, 12'h400);
    do_write(5, 2, 12'h810);
    do_write(6, 1, 12'h7FE);
    do_write(6, 3, 12'h800);
    do_load();
    chk("R2 ch5 input+offset", int'(dac_codes[5*DW +: DW]), 1024 + 16);
    chk("R2 ch6 gain+input", int'(dac_codes[6*DW +: DW]), 1024);
    chk_all("R2 other channels untouched");
  endtask

  task automatic t_gain_lsb();
    do_write(7, 3, 12'hFFF);
    do_write(7, 1, 12'h7FF);
    do_load();
    chk("R3 gain bit0 forced to 0", int'(dac_codes[7*DW +: DW]), 2047);
  endtask

  task automatic t_scales();
    do_write(8, 3, 12'h400);
    do_write(8, 1, 12'hBFE);
    do_write(9, 3, 12'hFFF);
    do_write(9, 1, 12'h3FE);
    do_write(10, 3, 12'h123);
    do_load();
    chk("R5 gain 0.75", int'(dac_codes[8*DW +: DW]), 768);
    chk("R5 gain 0.25", int'(dac_codes[9*DW +: DW]), 1023);
    chk("R5 unity gain", int'(dac_codes[10*DW +: DW]), 12'h123);
    chk_all("R5 all channels vs model");
  endtask

  task automatic t_saturate();
    do_write(11, 3, 12'hFFF);
    do_write(11, 2, 12'hFFF);
    do_write(12, 3, 12'h010);
    do_write(12, 2, 12'h000);
    do_write(13, 3, 12'h000);
    do_write(13, 2, 12'h7FF);
    do_load();
    chk("R6 overflow clamps", int'(dac_codes[11*DW +: DW]), 4095);
    chk("R6 underflow clamps", int'(dac_codes[12*DW +: DW]), 0);
    chk("R6 -1 clamps to 0", int'(dac_codes[13*DW +: DW]), 0);
  endtask

  task automatic t_double_buffer();
    do_write(14, 3, 12'h555);
    chk_all("R7 write alone leaves outputs");
    @(negedge clk);
    wr_valid = 1'b1; wr_chan = 5'd14; wr_sel = 2'b11; wr_data = 12'hAAA;
    load_i = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; load_i = 1'b0;
    model_load();
    model_write(14, 3, 12'hAAA);
    chk("R8 same-cycle load uses old input", int'(dac_codes[14*DW +: DW]), 12'h555);
    chk_all("R7 all channels updated together");
    do_load();
    chk("R8 later load picks new input", int'(dac_codes[14*DW +: DW]), 12'hAAA);
  endtask

  task automatic t_special();
    @(negedge clk);
    wr_valid = 1'b1; wr_chan = 5'd14; wr_sel = 2'b00; wr_data = 12'h001;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R9 sfr_hit pulses", int'(sfr_hit), 1);
    @(negedge clk);
    chk("R9 sfr_hit one cycle", int'(sfr_hit), 0);
    do_load();
    chk_all("R9 special write changes no register");
  endtask

  task automatic t_idle();
    @(negedge clk);
    wr_valid = 1'b0; wr_chan = 5'd20; wr_sel = 2'b11; wr_data = 12'hFFF;
    repeat (2) @(negedge clk);
    wr_sel = 2'b01; wr_data = 12'h000;
    repeat (2) @(negedge clk);
    do_load();
    chk("R10 idle inputs ignored", int'(dac_codes[20*DW +: DW]), 0);
    chk_all("R10 all channels unchanged");
  endtask

  initial begin
    t_reset();
    t_decode();
    t_gain_lsb();
    t_scales();
    t_saturate();
    t_double_buffer();
    t_special();
    t_idle();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule